// File: doc/BRIEF.md
# ECC Error Status and Interrupt Unit

This block sits beside an error-correcting memory port and turns its one-cycle error indications into software-visible state. Each of the two error kinds, correctable single-bit and uncorrectable double-bit, has a sticky flag and an address register. The address register can record the failing address presented with the error. A level-sensitive maskable interrupt and a separate non-maskable interrupt are derived from the flags and from the enable bits.

Software reaches the block through a flat register port. A write takes a select code, a write strobe and an 8-bit data byte. A read returns the selected register on a 32-bit bus in the same cycle. The ECC enable bit comes out of reset at a value given by a configuration pin. It can be set at any time. Clearing it requires a two-byte key written beforehand, and one clear re-locks the key.

Top module: `ecc_err_irq`

## Requirements
- R1: After reset the two flags, both address registers, the latch enable and all three interrupt enables read 0, and irq and nmi are low. The ECC enable bit reads the value of eccEnRstVal sampled during reset.
- R2: Register select codes are 0 control (bit0 ECC enable, bit1 address-latch enable), 1 interrupt enable (bit0 single, bit1 double, bit2 NMI enable), 2 status (bit0 single flag, bit1 double flag), 3 clear, 4 single address, 5 double address and 6 key. The key register reads 0, and so do the unused codes and the unused bits.
- R3: While ECC is enabled, a sglErr pulse sets the single flag and a dblErr pulse sets the double flag. The flag is visible on the first clock edge after the pulse.
- R4: While a flag is set, further errors of its kind are not detected: neither the flag nor the address register of that kind changes.
- R5: Writing 1 to bit0 or bit1 of the clear register clears the single or double flag, and writing 0 leaves it unchanged. Reading the clear register returns the flags. If a clear falls in the same cycle as a newly detected error of the same kind on a flag that is clear, the flag ends set. If that flag was already set, it ends clear.
- R6: A detected single error loads errAddr into the single address register only if the latch enable and the single interrupt enable are both 1.
- R7: A detected double error loads errAddr into the double address register only if the latch enable is 1 and the double interrupt enable or the NMI enable is 1.
- R8: irq is high exactly when (single flag and single enable) or (double flag and double enable and not NMI enable).
- R9: nmi is high exactly when the double flag and the NMI enable are both 1. The NMI enable can be set by software but not cleared by it, and only reset clears it.
- R10: Writing control bit0 = 0 clears the ECC enable only when the key register has received 0xAE and then 0x75 as its two most recent writes. Any other key byte re-locks it. After one such clear the key is locked again. Writing bit0 = 1 sets the enable without a key.
- R11: While the ECC enable is 0, error pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccEnRstVal | input | 1 | Reset value of the ECC enable bit |
| sglErr | input | 1 | Single-bit error pulse from the memory port |
| dblErr | input | 1 | Double-bit error pulse from the memory port |
| errAddr | input | ADDR_W | Failing address accompanying an error pulse |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regWdata | input | KEY_W | Register write data |
| regRdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Maskable interrupt, level |
| nmi | output | 1 | Non-maskable interrupt, level |

## Verification
A write to the clear register can fall in the same clock as an error pulse of the same kind. The bench provokes this twice, once with the flag already set and once with it clear. It expects the flag to end clear in the first case and set in the second. In the second case it also expects the address register to take the new address. A key or control write can also coincide with an error pulse while the enable is being dropped. The detection then follows the enable value held before that edge. The reference model evaluates every clock with old state, and its status and irq predictions are compared each cycle.

// File: rtl/ecc_err_pkg.sv
`timescale 1ns/1ps
package ecc_err_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 3;
  localparam int NUM_CH = 2;   // channel 0 single error, channel 1 double error

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_IEN   = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_SADDR = 3'd4,
    SEL_DADDR = 3'd5,
    SEL_KEY   = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_e;

  // strobes and configuration from control to datapath
  typedef struct packed {
    logic clrSgl;
    logic clrDbl;
    logic eccOn;
    logic latchEn;
    logic sglIe;
    logic dblIe;
    logic nmiEn;
  } ctlStrobes_t;
endpackage

// File: rtl/ecc_err_ctrl.sv
`timescale 1ns/1ps
module ecc_err_ctrl
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_FIRST = 8'hAE,
  parameter logic [KEY_W-1:0] KEY_SECOND = 8'h75
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           eccEnRstVal,
  input  logic                           regWr,
  input  logic [SEL_W-1:0]               regSel,
  input  logic [KEY_W-1:0]               regWdata,
  input  logic [NUM_CH-1:0]              errFlags,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  capAddr,
  output logic [REG_W-1:0]               regRdata,
  output ctlStrobes_t                    st,
  output logic                           keyOpen
);
  keyState_e keyState;
  logic eccOn, latchEn, sglIe, dblIe, nmiEn;
  logic wrCtrl, wrIen, wrClr, wrKey, eccDrop;

  assign wrCtrl = regWr && (regSel == SEL_CTRL);
  assign wrIen  = regWr && (regSel == SEL_IEN);
  assign wrClr  = regWr && (regSel == SEL_CLR);
  assign wrKey  = regWr && (regSel == SEL_KEY);
  assign keyOpen = (keyState == KEY_OPEN);
  assign eccDrop = wrCtrl && !regWdata[0] && eccOn && keyOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_LOCKED;
    end else if (wrKey) begin
      if (regWdata == KEY_FIRST)
        keyState <= KEY_HALF;
      else if (keyState == KEY_HALF && regWdata == KEY_SECOND)
        keyState <= KEY_OPEN;
      else
        keyState <= KEY_LOCKED;
    end else if (eccDrop) begin
      keyState <= KEY_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eccOn   <= eccEnRstVal;
      latchEn <= 1'b0;
      sglIe   <= 1'b0;
      dblIe   <= 1'b0;
      nmiEn   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        latchEn <= regWdata[1];
        if (regWdata[0])
          eccOn <= 1'b1;
        else if (eccDrop)
          eccOn <= 1'b0;
      end
      if (wrIen) begin
        sglIe <= regWdata[0];
        dblIe <= regWdata[1];
        nmiEn <= nmiEn | regWdata[2];
      end
    end
  end

  always_comb begin
    st.clrSgl  = wrClr && regWdata[0];
    st.clrDbl  = wrClr && regWdata[1];
    st.eccOn   = eccOn;
    st.latchEn = latchEn;
    st.sglIe   = sglIe;
    st.dblIe   = dblIe;
    st.nmiEn   = nmiEn;
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CTRL:  regRdata = REG_W'({latchEn, eccOn});
      SEL_IEN:   regRdata = REG_W'({nmiEn, dblIe, sglIe});
      SEL_STAT,
      SEL_CLR:   regRdata = REG_W'(errFlags);
      SEL_SADDR: regRdata = REG_W'(capAddr[0]);
      SEL_DADDR: regRdata = REG_W'(capAddr[1]);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_dp.sv
`timescale 1ns/1ps
module ecc_err_dp
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    st,
  input  logic                           sglErr,
  input  logic                           dblErr,
  input  logic [ADDR_W-1:0]              errAddr,
  output logic [NUM_CH-1:0]              errFlags,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  capAddr,
  output logic                           irq,
  output logic                           nmi
);
  logic [NUM_CH-1:0] errIn, clrIn, capOk;

  assign errIn = {dblErr, sglErr};
  assign clrIn = {st.clrDbl, st.clrSgl};
  assign capOk = {st.latchEn && (st.dblIe || st.nmiEn), st.latchEn && st.sglIe};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic detect;
    assign detect = errIn[ch] && !errFlags[ch] && st.eccOn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errFlags[ch] <= 1'b0;
        capAddr[ch]  <= '0;
      end else begin
        errFlags[ch] <= detect || (errFlags[ch] && !clrIn[ch]);
        if (detect && capOk[ch])
          capAddr[ch] <= errAddr;
      end
    end
  end

  assign irq = (errFlags[0] && st.sglIe) || (errFlags[1] && st.dblIe && !st.nmiEn);
  assign nmi = errFlags[1] && st.nmiEn;
endmodule

// File: rtl/ecc_err_irq.sv
`timescale 1ns/1ps
module ecc_err_irq
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KEY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEnRstVal,
  input  logic              sglErr,
  input  logic              dblErr,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              regWr,
  input  logic [2:0]        regSel,
  input  logic [KEY_W-1:0]  regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              nmi
);
  ctlStrobes_t                   ctlSt;
  logic [NUM_CH-1:0]             errFlags;
  logic [NUM_CH-1:0][ADDR_W-1:0] capAddr;
  logic                          keyOpen;

  ecc_err_ctrl #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .eccEnRstVal(eccEnRstVal),
    .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .errFlags(errFlags), .capAddr(capAddr),
    .regRdata(regRdata), .st(ctlSt), .keyOpen(keyOpen)
  );

  ecc_err_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(ctlSt),
    .sglErr(sglErr), .dblErr(dblErr), .errAddr(errAddr),
    .errFlags(errFlags), .capAddr(capAddr), .irq(irq), .nmi(nmi)
  );
endmodule

// File: rtl/ecc_err_chk.sv
`timescale 1ns/1ps
module ecc_err_chk
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          sglErr,
  input ctlStrobes_t                   st,
  input logic [NUM_CH-1:0]             errFlags,
  input logic [NUM_CH-1:0][ADDR_W-1:0] capAddr,
  input logic                          keyOpen,
  input logic                          irq,
  input logic                          nmi
);
  AST_NMI_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    st.nmiEn |=> st.nmiEn); // R9

  AST_NMI_NEEDS_DED: assert property (@(posedge clk) disable iff (!rstN)
    nmi |-> errFlags[1]); // R9

  AST_NMI_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (st.nmiEn && !(errFlags[0] && st.sglIe)) |-> !irq); // R8

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags[0] && !st.clrSgl) |=> errFlags[0]); // R4

  AST_SADDR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !(sglErr && !errFlags[0] && st.eccOn && st.latchEn && st.sglIe) |=> $stable(capAddr[0])); // R6

  AST_OFF_NO_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (!st.eccOn && !errFlags[0]) |=> !errFlags[0]); // R11

  AST_ECC_DROP_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(st.eccOn) |-> $past(keyOpen)); // R10
endmodule

bind ecc_err_irq ecc_err_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sglErr(sglErr), .st(ctlSt),
  .errFlags(errFlags), .capAddr(capAddr), .keyOpen(keyOpen),
  .irq(irq), .nmi(nmi)
);

// File: tb/ecc_err_irq_tb.sv
`timescale 1ns/1ps
module ecc_err_irq_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccEnRstVal = 1'b1;
  logic sglErr = 1'b0, dblErr = 1'b0;
  logic [AW-1:0] errAddr = '0;
  logic regWr = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [31:0] regRdata;
  logic irq, nmi;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_irq #(.ADDR_W(AW), .KEY_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .eccEnRstVal(eccEnRstVal),
    .sglErr(sglErr), .dblErr(dblErr), .errAddr(errAddr),
    .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .nmi(nmi)
  );

  // behavioural reference model
  bit mEcc = 1, mLat = 0, mSie = 0, mDie = 0, mNmi = 0, mSf = 0, mDf = 0;
  logic [AW-1:0] mSa = '0, mDa = '0;
  int mKey = 0; // 0 locked, 1 first byte seen, 2 open

  always @(posedge clk) begin
    if (!rstN) begin
      mEcc = eccEnRstVal; mLat = 0; mSie = 0; mDie = 0; mNmi = 0;
      mSf = 0; mDf = 0; mSa = '0; mDa = '0; mKey = 0;
    end else begin
      bit sDet, dDet, cS, cD;
      sDet = sglErr && !mSf && mEcc;
      dDet = dblErr && !mDf && mEcc;
      cS = regWr && regSel == 3 && regWdata[0];
      cD = regWr && regSel == 3 && regWdata[1];
      if (sDet && mLat && mSie) mSa = errAddr;
      if (dDet && mLat && (mDie || mNmi)) mDa = errAddr;
      mSf = sDet || (mSf && !cS);
      mDf = dDet || (mDf && !cD);
      if (regWr && regSel == 0) begin
        mLat = regWdata[1];
        if (regWdata[0]) mEcc = 1;
        else if (mKey == 2 && mEcc) begin mEcc = 0; mKey = 0; end
      end
      if (regWr && regSel == 1) begin
        mSie = regWdata[0]; mDie = regWdata[1]; mNmi = mNmi || regWdata[2];
      end
      if (regWr && regSel == 6) begin
        if (regWdata == 8'hAE) mKey = 1;
        else if (mKey == 1 && regWdata == 8'h75) mKey = 2;
        else mKey = 0;
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] sel);
    case (sel)
      3'd0: return {30'd0, mLat, mEcc};
      3'd1: return {29'd0, mNmi, mDie, mSie};
      3'd2, 3'd3: return {30'd0, mDf, mSf};
      3'd4: return mSa;
      3'd5: return mDa;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven; compare against the model after the edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rstN) begin
      check("R8 irq vs model", {31'd0, irq}, {31'd0, (mSf && mSie) || (mDf && mDie && !mNmi)});
      check("R9 nmi vs model", {31'd0, nmi}, {31'd0, mDf && mNmi});
      check("R2 rdata vs model", regRdata, modelRead(regSel));
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    regWr = 1; regSel = sel; regWdata = d;
    cyc();
    regWr = 0; regWdata = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    regSel = sel;
    #1;
    check(tag, regRdata, exp);
  endtask

  task automatic pulse(input bit s, input bit d, input logic [AW-1:0] a);
    sglErr = s; dblErr = d; errAddr = a;
    cyc();
    sglErr = 0; dblErr = 0;
  endtask

  task automatic doReset(input bit val);
    eccEnRstVal = val; rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    doReset(1'b1);
    // R1 reset state
    rd("R1 ctrl after reset", 3'd0, 32'h1);
    rd("R1 ien after reset", 3'd1, 32'h0);
    rd("R1 status after reset", 3'd2, 32'h0);
    rd("R1 saddr after reset", 3'd4, 32'h0);
    check("R1 irq low", {31'd0, irq}, 32'd0);
    check("R1 nmi low", {31'd0, nmi}, 32'd0);
    // R3 single flag without enables; R6 no capture
    pulse(1, 0, 32'h0000_1000);
    rd("R3 single flag set", 3'd2, 32'h1);
    rd("R5 clear reg reads flags", 3'd3, 32'h1);
    rd("R6 no capture without enables", 3'd4, 32'h0);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd3, 8'h1);
    rd("R5 single flag cleared", 3'd2, 32'h0);
    // R6 capture with latch and single enable
    wr(3'd0, 8'h3);
    wr(3'd1, 8'h1);
    pulse(1, 0, 32'hCAFE_0010);
    rd("R6 single address captured", 3'd4, 32'hCAFE_0010);
    check("R8 irq from single", {31'd0, irq}, 32'd1);
    // R4 pending flag blocks detection
    pulse(1, 0, 32'hCAFE_0020);
    rd("R4 address held while pending", 3'd4, 32'hCAFE_0010);
    // R5 collision: flag set, clear + error same cycle -> clear
    sglErr = 1; errAddr = 32'hCAFE_0030;
    wr(3'd3, 8'h1);
    sglErr = 0;
    rd("R5 clear wins over blocked error", 3'd2, 32'h0);
    rd("R5 blocked error not captured", 3'd4, 32'hCAFE_0010);
    // R5 collision: flag clear, clear + error same cycle -> set
    sglErr = 1; errAddr = 32'hCAFE_0040;
    wr(3'd3, 8'h1);
    sglErr = 0;
    rd("R5 new error survives clear", 3'd2, 32'h1);
    rd("R5 new error captured", 3'd4, 32'hCAFE_0040);
    wr(3'd3, 8'h3);
    // R7 double error, no double enable: flag but no capture
    pulse(0, 1, 32'hBEEF_0001);
    rd("R3 double flag set", 3'd2, 32'h2);
    rd("R7 no double capture", 3'd5, 32'h0);
    check("R8 irq low, double masked", {31'd0, irq}, 32'd0);
    wr(3'd1, 8'h2);
    check("R8 irq from double", {31'd0, irq}, 32'd1);
    // R9 NMI overrides maskable double interrupt
    wr(3'd1, 8'h6);
    check("R9 nmi high", {31'd0, nmi}, 32'd1);
    check("R8 irq suppressed by nmi enable", {31'd0, irq}, 32'd0);
    wr(3'd1, 8'h0);
    rd("R9 nmi enable sticks", 3'd1, 32'h4);
    wr(3'd3, 8'h2);
    check("R9 nmi drops with flag", {31'd0, nmi}, 32'd0);
    pulse(0, 1, 32'hBEEF_0002);
    rd("R7 capture via nmi enable", 3'd5, 32'hBEEF_0002);
    wr(3'd3, 8'h2);
    // both in the same cycle
    wr(3'd1, 8'h3);
    pulse(1, 1, 32'h0000_ABCD);
    rd("R3 both flags", 3'd2, 32'h3);
    rd("R6 single addr in dual event", 3'd4, 32'h0000_ABCD);
    wr(3'd3, 8'h3);
    // R10 key sequence
    wr(3'd0, 8'h2);
    rd("R10 locked clear ignored", 3'd0, 32'h3);
    wr(3'd6, 8'hAE); wr(3'd6, 8'h75); wr(3'd0, 8'h2);
    rd("R10 unlocked clear", 3'd0, 32'h2);
    wr(3'd0, 8'h3);
    rd("R10 set without key", 3'd0, 32'h3);
    wr(3'd0, 8'h2);
    rd("R10 relocked after one clear", 3'd0, 32'h3);
    wr(3'd6, 8'hAE); wr(3'd6, 8'h12); wr(3'd6, 8'h75); wr(3'd0, 8'h2);
    rd("R10 wrong middle key", 3'd0, 32'h3);
    wr(3'd6, 8'hAE); wr(3'd6, 8'h75); wr(3'd6, 8'h33); wr(3'd0, 8'h2);
    rd("R10 wrong key relocks", 3'd0, 32'h3);
    wr(3'd6, 8'hAE); wr(3'd6, 8'hAE); wr(3'd6, 8'h75); wr(3'd0, 8'h2);
    rd("R10 repeated first byte", 3'd0, 32'h2);
    rd("R2 key reads zero", 3'd6, 32'h0);
    rd("R2 unused code reads zero", 3'd7, 32'h0);
    // R11 errors ignored while disabled
    pulse(1, 1, 32'h5555_0000);
    rd("R11 no flags while off", 3'd2, 32'h0);
    rd("R11 no address while off", 3'd4, 32'h0000_ABCD);
    // R1 other reset value, NMI enable cleared by reset
    doReset(1'b0);
    rd("R1 ctrl reset value 0", 3'd0, 32'h0);
    rd("R9 reset clears nmi enable", 3'd1, 32'h0);
    rd("R1 daddr reset", 3'd5, 32'h0);
    pulse(1, 0, 32'h1);
    rd("R11 off from reset", 3'd2, 32'h0);
    repeat (2) cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule